// File: doc/BRIEF.md
# CAN Fault-Confinement Error State Tracker

This block keeps the transmit and receive error counters of a CAN node and works out from them whether the node is in the warning, error-passive or bus-off condition. The protocol core drives four one-cycle event pulses into it: transmit error, receive error, transmit success and receive success. Software reaches the block through a simple write port. That port loads the counter word, sets the warning threshold, acknowledges interrupt flags and programs the interrupt enable mask.

Two sticky interrupt flags record changes in the fault-confinement state. One flag covers the bus-off and warning indications. The other covers entry into and exit from error-passive. A single level interrupt line combines the flags with the enable mask. While the controller sits in reset mode, the protocol events are ignored. The recovery sequence that follows bus-off is handled outside this block.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters are zero, the warning limit is 96, the flag and enable registers are zero and `irq` is low.
- R2: A transmit error pulse adds 8 to the TX counter. A receive error pulse adds 1 to the RX counter, and the RX counter saturates at 255.
- R3: A success pulse subtracts 1 from its counter and stops at 0. If an error pulse and a success pulse reach the same counter in the same cycle, the error takes effect and the success is dropped.
- R4: In the counter word, bits 7:0 hold the TX counter and bits 23:16 hold the RX counter. All other bits read as zero. A write with select 0 loads both counters from those fields, so writing zero clears both counters and also clears bus-off.
- R5: Status bit 6 (warning) is high while either counter is at or above the warning limit. The limit is written with select 1, bits 7:0.
- R6: The node is error-passive while either counter exceeds 127. Interrupt flag bit 5 sets one cycle after the node enters or leaves error-passive.
- R7: A transmit error that would take the TX counter past 255 sets status bit 7 (bus-off) and puts 255 in the TX counter. While bus-off is set, the TX counter ignores all events. Bus-off clears only when the counter word is written.
- R8: Interrupt flag bit 2 sets one cycle after status bit 7 or status bit 6 changes value.
- R9: A write with select 2 clears every flag whose data bit is 1. If a flag sets in the same cycle as its clear, the set wins. Flags that are not written stay as they are.
- R10: A write with select 3 loads the enable mask, which uses the same bit positions as the flags. `irq` is high exactly when some flag and its matching enable bit are both set.
- R11: While `resetMode` is high, the four event pulses have no effect on the counters. Register writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetMode | input | 1 | Controller reset mode; blocks the event pulses |
| txErr | input | 1 | Transmit error event pulse |
| rxErr | input | 1 | Receive error event pulse |
| txOk | input | 1 | Successful transmission pulse |
| rxOk | input | 1 | Successful reception pulse |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 counter word, 1 warning limit, 2 flag clear, 3 enable mask |
| wrData | input | 32 | Write data |
| errCount | output | 32 | Counter word (TX in 7:0, RX in 23:16) |
| statusBits | output | 8 | Bit 7 bus-off, bit 6 warning, other bits zero |
| intFlags | output | 8 | Sticky interrupt flags (bit 2 state change, bit 5 passive change) |
| intEnable | output | 8 | Interrupt enable mask |
| warnLimit | output | 8 | Current warning threshold |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 8-bit counters, a step of 8 for transmit errors, a passive threshold of 127 and a reset warning limit of 96. With these values, loading the counter word puts the node directly at the interesting edges. The RX counter can start at 127, one step below passive, and the TX counter at 248, one error below bus-off, so no long chains of events are needed. A warning limit lowered to 10 lets the warning bit cross in both directions with only a few receive pulses. The bench also lines up a flag-clearing write with a flag-setting state change in the same cycle, which checks that the set takes priority.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic txUp;
    logic txDown;
    logic rxUp;
    logic rxDown;
    logic load;
  } cntStrobe_t;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_FLAGS  = 2'd2,
    SEL_ENABLE = 2'd3
  } regSel_t;

  localparam int FLAG_STATE_BIT   = 2;
  localparam int FLAG_PASSIVE_BIT = 5;
  localparam int STAT_BUSOFF_BIT  = 7;
  localparam int STAT_WARN_BIT    = 6;

endpackage

// File: rtl/fc_counters.sv
module fc_counters
  import canfc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadTx,
  input  logic [CNT_W-1:0] loadRx,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             busOff
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] TX_STEPV = CNT_W'(TX_STEP);
  localparam logic [CNT_W-1:0] RX_STEPV = CNT_W'(RX_STEP);
  localparam logic [CNT_W-1:0] TX_EDGE  = CNT_MAX - TX_STEPV;
  localparam logic [CNT_W-1:0] RX_EDGE  = CNT_MAX - RX_STEPV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      busOff <= 1'b0;
    end else if (strobe.load) begin
      txCnt  <= loadTx;
      rxCnt  <= loadRx;
      busOff <= 1'b0;
    end else begin
      if (!busOff) begin
        if (strobe.txUp) begin
          if (txCnt > TX_EDGE) begin
            busOff <= 1'b1;
            txCnt  <= CNT_MAX;
          end else begin
            txCnt <= txCnt + TX_STEPV;
          end
        end else if (strobe.txDown && txCnt != '0) begin
          txCnt <= txCnt - 1'b1;
        end
      end
      if (strobe.rxUp) begin
        rxCnt <= (rxCnt > RX_EDGE) ? CNT_MAX : rxCnt + RX_STEPV;
      end else if (strobe.rxDown && rxCnt != '0) begin
        rxCnt <= rxCnt - 1'b1;
      end
    end
  end

  // R7
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !strobe.load) |=> $stable(txCnt));

  // R4
  zero_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && loadTx == '0 && loadRx == '0) |=> (txCnt == '0 && rxCnt == '0 && !busOff));

endmodule

// File: rtl/fc_control.sv
module fc_control
  import canfc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int WORD_W        = 32,
  parameter int FLAG_W        = 8,
  parameter int TX_LSB        = 0,
  parameter int RX_LSB        = 16,
  parameter int PASSIVE_LIMIT = 127,
  parameter int WARN_DEFAULT  = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetMode,
  input  logic              txErr,
  input  logic              rxErr,
  input  logic              txOk,
  input  logic              rxOk,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]  txCnt,
  input  logic [CNT_W-1:0]  rxCnt,
  input  logic              busOff,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadTx,
  output logic [CNT_W-1:0]  loadRx,
  output logic [7:0]        statusBits,
  output logic [FLAG_W-1:0] intFlags,
  output logic [FLAG_W-1:0] intEnable,
  output logic [CNT_W-1:0]  warnLimit,
  output logic              irq
);

  localparam logic [CNT_W-1:0] PASSIVE_V = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] WARN_V    = CNT_W'(WARN_DEFAULT);

  regSel_t sel;
  logic    wrCount, wrLimit, wrFlags, wrEnable;
  logic    warnNow, passiveNow;
  logic    prevWarn, prevBusOff, prevPassive;
  logic    stateChange, passiveChange;
  logic [FLAG_W-1:0] flagsNext;

  assign sel      = regSel_t'(wrSel);
  assign wrCount  = wrEn && (sel == SEL_COUNT);
  assign wrLimit  = wrEn && (sel == SEL_LIMIT);
  assign wrFlags  = wrEn && (sel == SEL_FLAGS);
  assign wrEnable = wrEn && (sel == SEL_ENABLE);

  // Event decode: errors take precedence over successes on one counter
  always_comb begin
    strobe.txUp   = !resetMode && txErr;
    strobe.txDown = !resetMode && txOk && !txErr;
    strobe.rxUp   = !resetMode && rxErr;
    strobe.rxDown = !resetMode && rxOk && !rxErr;
    strobe.load   = wrCount;
  end

  assign loadTx = wrData[TX_LSB +: CNT_W];
  assign loadRx = wrData[RX_LSB +: CNT_W];

  assign warnNow    = (txCnt >= warnLimit) || (rxCnt >= warnLimit);
  assign passiveNow = (txCnt > PASSIVE_V) || (rxCnt > PASSIVE_V);

  always_comb begin
    statusBits = '0;
    statusBits[STAT_BUSOFF_BIT] = busOff;
    statusBits[STAT_WARN_BIT]   = warnNow;
  end

  assign stateChange   = (warnNow != prevWarn) || (busOff != prevBusOff);
  assign passiveChange = (passiveNow != prevPassive);

  always_comb begin
    flagsNext = intFlags;
    if (wrFlags) flagsNext = flagsNext & ~wrData[FLAG_W-1:0];
    if (stateChange)   flagsNext[FLAG_STATE_BIT]   = 1'b1;
    if (passiveChange) flagsNext[FLAG_PASSIVE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWarn    <= 1'b0;
      prevBusOff  <= 1'b0;
      prevPassive <= 1'b0;
      intFlags    <= '0;
      intEnable   <= '0;
      warnLimit   <= WARN_V;
    end else begin
      prevWarn    <= warnNow;
      prevBusOff  <= busOff;
      prevPassive <= passiveNow;
      intFlags    <= flagsNext;
      if (wrEnable) intEnable <= wrData[FLAG_W-1:0];
      if (wrLimit)  warnLimit <= wrData[CNT_W-1:0];
    end
  end

  assign irq = |(intFlags & intEnable);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intFlags[FLAG_STATE_BIT] && !(wrFlags && wrData[FLAG_STATE_BIT])) |=> intFlags[FLAG_STATE_BIT]);

  // R6
  passive_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((txCnt > PASSIVE_V) || (rxCnt > PASSIVE_V)) !=
     (($past(txCnt) > PASSIVE_V) || ($past(rxCnt) > PASSIVE_V))) |=> intFlags[FLAG_PASSIVE_BIT]);

  // R11
  reset_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetMode && !wrCount) |=> ($stable(txCnt) && $stable(rxCnt)));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import canfc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int WORD_W        = 32,
  parameter int FLAG_W        = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_STEP       = 1,
  parameter int PASSIVE_LIMIT = 127,
  parameter int WARN_DEFAULT  = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetMode,
  input  logic              txErr,
  input  logic              rxErr,
  input  logic              txOk,
  input  logic              rxOk,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] errCount,
  output logic [7:0]        statusBits,
  output logic [FLAG_W-1:0] intFlags,
  output logic [FLAG_W-1:0] intEnable,
  output logic [CNT_W-1:0]  warnLimit,
  output logic              irq
);

  localparam int TX_LSB = 0;
  localparam int RX_LSB = 16;

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] loadTx, loadRx, txCnt, rxCnt;
  logic             busOff;

  fc_control #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .FLAG_W(FLAG_W),
    .TX_LSB(TX_LSB), .RX_LSB(RX_LSB),
    .PASSIVE_LIMIT(PASSIVE_LIMIT), .WARN_DEFAULT(WARN_DEFAULT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .txErr(txErr), .rxErr(rxErr), .txOk(txOk), .rxOk(rxOk),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txCnt(txCnt), .rxCnt(rxCnt), .busOff(busOff),
    .strobe(strobe), .loadTx(loadTx), .loadRx(loadRx),
    .statusBits(statusBits), .intFlags(intFlags), .intEnable(intEnable),
    .warnLimit(warnLimit), .irq(irq)
  );

  fc_counters #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadTx(loadTx), .loadRx(loadRx),
    .txCnt(txCnt), .rxCnt(rxCnt), .busOff(busOff)
  );

  always_comb begin
    errCount = '0;
    errCount[TX_LSB +: CNT_W] = txCnt;
    errCount[RX_LSB +: CNT_W] = rxCnt;
  end

endmodule

// File: tb/can_fault_tracker_tb.sv
module can_fault_tracker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetMode = 1'b0;
  logic        txErr = 1'b0, rxErr = 1'b0, txOk = 1'b0, rxOk = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] errCount;
  logic [7:0]  statusBits, intFlags, intEnable, warnLimit;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_fault_tracker u_dut (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .txErr(txErr), .rxErr(rxErr), .txOk(txOk), .rxOk(rxOk),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .errCount(errCount), .statusBits(statusBits), .intFlags(intFlags),
    .intEnable(intEnable), .warnLimit(warnLimit), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic te, input logic re, input logic to, input logic ro);
    txErr = te; rxErr = re; txOk = to; rxOk = ro;
    @(negedge clk);
    txErr = 0; rxErr = 0; txOk = 0; rxOk = 0;
  endtask

  task automatic regWrite(input logic [1:0] s, input logic [31:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic clearFlags();
    idle(2);
    regWrite(2'd2, 32'hFF);
  endtask

  task automatic testReset();
    check("R1 count", errCount, 0);
    check("R1 limit", warnLimit, 96);
    check("R1 flags", intFlags, 0);
    check("R1 enable", intEnable, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testCounting();
    for (int i = 0; i < 3; i++) pulse(1, 0, 0, 0);
    for (int i = 0; i < 2; i++) pulse(0, 1, 0, 0);
    check("R2 tx+8 rx+1", errCount, 32'h0002_0018);
    pulse(0, 0, 1, 1);
    check("R3 success decrement", errCount, 32'h0001_0017);
    pulse(1, 0, 1, 0);
    check("R3 error wins", errCount, 32'h0001_001F);
    pulse(0, 0, 0, 1);
    pulse(0, 0, 0, 1);
    check("R3 rx floor at zero", errCount[23:16], 0);
    regWrite(2'd0, 32'h00FF_0000);
    pulse(0, 1, 0, 0);
    check("R2 rx saturates", errCount[23:16], 8'hFF);
  endtask

  task automatic testLoad();
    regWrite(2'd0, 32'hABC4_5633);
    check("R4 field load", errCount, 32'h00C4_0033);
    regWrite(2'd0, 32'h0);
    check("R4 zero clears", errCount, 0);
    clearFlags();
  endtask

  task automatic testWarn();
    regWrite(2'd1, 32'd10);
    check("R5 limit write", warnLimit, 10);
    for (int i = 0; i < 9; i++) pulse(0, 1, 0, 0);
    check("R5 below limit", statusBits[6], 0);
    pulse(0, 1, 0, 0);
    check("R5 at limit", statusBits[6], 1);
    idle(1);
    check("R8 flag on warn rise", intFlags[2], 1);
    regWrite(2'd2, 32'h04);
    check("R9 w1c clears", intFlags, 0);
    pulse(0, 0, 0, 1);
    check("R5 below again", statusBits[6], 0);
    idle(1);
    check("R8 flag on warn fall", intFlags[2], 1);
    regWrite(2'd1, 32'd96);
    regWrite(2'd0, 32'h0);
    clearFlags();
  endtask

  task automatic testPassive();
    regWrite(2'd0, 32'h007F_0000);
    clearFlags();
    check("R6 not passive at 127", intFlags[5], 0);
    regWrite(2'd3, 32'h20);
    pulse(0, 1, 0, 0);
    idle(1);
    check("R6 flag on entry", intFlags[5], 1);
    check("R10 irq with enable", irq, 1);
    regWrite(2'd2, 32'h20);
    check("R10 irq low after ack", irq, 0);
    pulse(0, 0, 0, 1);
    idle(1);
    check("R6 flag on exit", intFlags[5], 1);
    regWrite(2'd3, 32'h04);
    check("R10 masked flag no irq", irq, 0);
    regWrite(2'd3, 32'h0);
    regWrite(2'd0, 32'h0);
    clearFlags();
  endtask

  task automatic testSetWins();
    regWrite(2'd0, 32'h0080_0000);
    clearFlags();
    txOk = 0; rxOk = 1;
    @(negedge clk);
    rxOk = 0;
    regWrite(2'd2, 32'h20);
    check("R9 set beats clear", intFlags[5], 1);
    regWrite(2'd0, 32'h0);
    clearFlags();
  endtask

  task automatic testBusOff();
    regWrite(2'd0, 32'h0000_00F8);
    clearFlags();
    pulse(1, 0, 0, 0);
    check("R7 busoff set", statusBits[7], 1);
    check("R7 tx at max", errCount[7:0], 8'hFF);
    idle(1);
    check("R8 flag on busoff", intFlags[2], 1);
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0);
    check("R7 tx held", errCount[7:0], 8'hFF);
    regWrite(2'd0, 32'h0);
    check("R7 busoff cleared by write", statusBits[7], 0);
    check("R4 counters zero", errCount, 0);
    clearFlags();
  endtask

  task automatic testResetMode();
    regWrite(2'd0, 32'h0005_0005);
    resetMode = 1'b1;
    pulse(1, 1, 0, 0);
    pulse(0, 0, 1, 1);
    check("R11 events ignored", errCount, 32'h0005_0005);
    regWrite(2'd0, 32'h0);
    check("R11 writes still work", errCount, 0);
    resetMode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testCounting();
    testLoad();
    testWarn();
    testPassive();
    testSetWins();
    testBusOff();
    testResetMode();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule